// File: doc/BRIEF.md
# Regulator fault supervisor

This block is the protection supervisor for a multiphase buck controller. It takes comparator results that are already digitized: output over-voltage, output sagging well under the DAC target, over-current, input-supply lockout, plus the enable request and a soft-start-in-progress flag. From these it produces the power-good flag, the driver-enable flag, a soft-start permit, and two gate override commands: force every high-side gate off, and force every low-side gate on.

Three pieces of state shape its behaviour. The first is a debounce timer that drops power-good only when the output has stayed low for a programmable number of clock cycles. The second is a trip counter that latches a shutdown on the eighth over-voltage event counted outside soft-start. The third is an over-current latch that stays set until enable is removed or the input lockout cycles. The over-voltage threshold choice (a smaller or larger margin above the DAC) is made in the analog comparator. The block only passes that mode bit through to it.

Top module: `reg_fault_supervisor`

## Requirements
- R1: During reset, and afterwards while `en_i` is low, `pgood_o`, `drv_en_o`, `ss_run_o`, `hs_off_o` and `ls_on_o` are all 0.
- R2: When enabled with `uvlo_i` low, `pgood_o` is 1 only while `ss_active_i` is 0 and no over-voltage, over-current, timed under-voltage or latched shutdown is present. `pgood_o` is 0 in every cycle that `ss_active_i` is 1.
- R3: When enabled and not shut down, `ov_flag_i` at 1 gives `pgood_o`=0, `hs_off_o`=1 and `ls_on_o`=1 in the same cycle. All three return to normal in the cycle after the flag clears, and `drv_en_o` stays 1.
- R4: Each 0-to-1 change of `ov_flag_i` sampled while enabled and `ss_active_i` is 0 counts as one trip. After the clock edge that samples the eighth trip, `drv_en_o`=0, `hs_off_o`=1 and `ls_on_o`=0, and this holds after the flag clears. Seven trips do not shut down.
- R5: Over-voltage rising edges sampled while `ss_active_i` is 1 are not counted and never cause the shutdown.
- R6: `uv_flag_i` held at 1 for `UV_CYCLES` consecutive sampled edges drives `pgood_o` low after the last of them, and not before. A single sampled 0 restarts the count from zero.
- R7: `oc_flag_i` at 1 while enabled drives `drv_en_o` and `pgood_o` to 0 in the same cycle. After the edge that samples it, both stay 0 even when the flag clears and `ss_active_i` toggles.
- R8: The over-current latch, the trip count and the over-voltage shutdown are cleared only by an edge that samples `en_i`=0 or `uvlo_i`=1. After that, `drv_en_o` returns to 1 as soon as the block is enabled again.
- R9: While `uvlo_i` is 1, `drv_en_o` and `ss_run_o` are 0. When enabled with `uvlo_i` at 0, `ss_run_o` is 1.
- R10: `ov_thr_sel_o` follows `ov_mode_i` in the same cycle (0 selects the smaller margin, 1 the larger).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Enable request |
| uvlo_i | input | 1 | Input supply below its lockout threshold |
| ss_active_i | input | 1 | Soft-start ramp in progress |
| ov_mode_i | input | 1 | Over-voltage margin select |
| ov_flag_i | input | 1 | Output above over-voltage threshold |
| uv_flag_i | input | 1 | Output more than the sag margin below DAC |
| oc_flag_i | input | 1 | Current above limit |
| pgood_o | output | 1 | Power-good flag |
| drv_en_o | output | 1 | Gate driver enable |
| ss_run_o | output | 1 | Soft-start permitted |
| hs_off_o | output | 1 | Force all high-side gates off |
| ls_on_o | output | 1 | Force all low-side gates on |
| ov_thr_sel_o | output | 1 | Margin select passed to the comparator |

## Verification
Flag-driven outputs such as gate overrides, the immediate over-current cut and the threshold select react in the same cycle. The bench therefore checks them 1 ns after driving the input on a falling edge, before any rising edge. Stored results (the trip count, the latches and the debounce timer) change on the rising edge that samples the stimulus. The bench counts the edges that occur between a falling-edge drive and the falling edge where it samples, and checks the debounce at exactly `UV_CYCLES`-1 and `UV_CYCLES` edges. Recovery is checked one edge after the clearing input is sampled.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  localparam int unsigned OV_TRIPS_DEF = 8;
  localparam int unsigned UV_CYCLES_DEF = 1_000_000; // 5 ms at 200 MHz

  typedef struct packed {
    logic ov_shut;
    logic oc_lat;
    logic uv_fault;
  } fault_vec_t;

  function automatic logic any_fault(input fault_vec_t f);
    return f.ov_shut | f.oc_lat | f.uv_fault;
  endfunction
endpackage

// File: rtl/fsup_uv_timer.sv
module fsup_uv_timer #(
  parameter int unsigned UV_CYCLES = fsup_pkg::UV_CYCLES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic uv_i,
  output logic fault_o
);
  localparam int unsigned CW = $clog2(UV_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(UV_CYCLES);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clr_i || !uv_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != LIM) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign fault_o = (cnt_q == LIM);
endmodule

// File: rtl/fsup_ov_counter.sv
module fsup_ov_counter #(
  parameter int unsigned TRIPS = fsup_pkg::OV_TRIPS_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic count_ok_i,
  input  logic ov_i,
  output logic shut_o
);
  localparam int unsigned CW = $clog2(TRIPS + 1);
  localparam logic [CW-1:0] LAST = CW'(TRIPS - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          prev_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          shut_q, shut_d;
  logic          rise, cnt_en;

  assign rise = ov_i & ~prev_q;

  always_comb begin
    cnt_d  = cnt_q;
    shut_d = shut_q;
    cnt_en = 1'b0;
    if (clr_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
      shut_d = 1'b0;
    end else if (rise && count_ok_i && !shut_q) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + ONE;
      if (cnt_q == LAST) shut_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
      shut_q <= 1'b0;
    end else begin
      prev_q <= ov_i;
      if (cnt_en) begin
        cnt_q  <= cnt_d;
        shut_q <= shut_d;
      end
    end
  end

  assign shut_o = shut_q;
endmodule

// File: rtl/fsup_oc_latch.sv
module fsup_oc_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic oc_i,
  output logic lat_o
);
  logic lat_q, lat_d, lat_en;

  always_comb begin
    lat_en = clr_i | oc_i;
    lat_d  = ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= 1'b0;
    else if (lat_en) lat_q <= lat_d;
  end

  assign lat_o = lat_q;
endmodule

// File: rtl/reg_fault_supervisor.sv
module reg_fault_supervisor #(
  parameter int unsigned UV_CYCLES = fsup_pkg::UV_CYCLES_DEF,
  parameter int unsigned OV_TRIPS  = fsup_pkg::OV_TRIPS_DEF,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic uvlo_i,
  input  logic ss_active_i,
  input  logic ov_mode_i,
  input  logic ov_flag_i,
  input  logic uv_flag_i,
  input  logic oc_flag_i,
  output logic pgood_o,
  output logic drv_en_o,
  output logic ss_run_o,
  output logic hs_off_o,
  output logic ls_on_o,
  output logic ov_thr_sel_o
);
  import fsup_pkg::*;

  // reset release synchronizer
  logic [RST_STAGES-1:0] rst_sh_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= '0;
    else        rst_sh_q <= {rst_sh_q[RST_STAGES-2:0], 1'b1};
  end

  logic rst_ok, active, clr;
  assign rst_ok = rst_sh_q[RST_STAGES-1];
  assign active = rst_ok & en_i & ~uvlo_i;
  assign clr    = ~active;

  fault_vec_t flt;

  fsup_uv_timer #(.UV_CYCLES(UV_CYCLES)) u_uv (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .uv_i(uv_flag_i), .fault_o(flt.uv_fault)
  );

  fsup_ov_counter #(.TRIPS(OV_TRIPS)) u_ov (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .count_ok_i(~ss_active_i),
    .ov_i(ov_flag_i), .shut_o(flt.ov_shut)
  );

  fsup_oc_latch u_oc (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .oc_i(oc_flag_i), .lat_o(flt.oc_lat)
  );

  logic stop_drv;
  assign stop_drv = flt.ov_shut | flt.oc_lat | oc_flag_i;

  always_comb begin
    ss_run_o     = active;
    drv_en_o     = active & ~stop_drv;
    hs_off_o     = active & (ov_flag_i | flt.ov_shut);
    ls_on_o      = active & ov_flag_i & ~flt.ov_shut;
    pgood_o      = active & ~ss_active_i & ~ov_flag_i & ~oc_flag_i & ~any_fault(flt);
    ov_thr_sel_o = ov_mode_i;
  end
endmodule

// File: rtl/fsup_chk.sv
module fsup_chk (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic uvlo_i,
  input logic ss_active_i,
  input logic ov_flag_i,
  input logic oc_flag_i,
  input logic pgood_o,
  input logic drv_en_o,
  input logic ss_run_o,
  input logic hs_off_o,
  input logic ls_on_o
);
  // R2
  ss_blocks_pgood_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_active_i |-> !pgood_o);
  // R3
  ov_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_flag_i && en_i && !uvlo_i) |-> (hs_off_o && !pgood_o));
  // R3
  ov_low_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_flag_i && drv_en_o) |-> ls_on_o);
  // R7
  oc_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_flag_i |-> !drv_en_o);
  // R7
  oc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_flag_i && en_i && !uvlo_i) |=> !drv_en_o);
  // R9
  uvlo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |-> (!drv_en_o && !ss_run_o));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (!pgood_o && !drv_en_o && !hs_off_o && !ls_on_o));
endmodule

bind reg_fault_supervisor fsup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .uvlo_i(uvlo_i),
  .ss_active_i(ss_active_i), .ov_flag_i(ov_flag_i), .oc_flag_i(oc_flag_i),
  .pgood_o(pgood_o), .drv_en_o(drv_en_o), .ss_run_o(ss_run_o),
  .hs_off_o(hs_off_o), .ls_on_o(ls_on_o)
);

// File: tb/sim_reg_fault_supervisor.sv
`timescale 1ns/1ps
module sim_reg_fault_supervisor;
  localparam int UVN = 20;

  logic clk = 1'b0;
  logic rst_n, en, uvlo, ss, ovm, ov, uv, oc;
  logic pgood, drv_en, ss_run, hs_off, ls_on, thr_sel;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  reg_fault_supervisor #(.UV_CYCLES(UVN)) u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en), .uvlo_i(uvlo), .ss_active_i(ss),
    .ov_mode_i(ovm), .ov_flag_i(ov), .uv_flag_i(uv), .oc_flag_i(oc),
    .pgood_o(pgood), .drv_en_o(drv_en), .ss_run_o(ss_run), .hs_off_o(hs_off),
    .ls_on_o(ls_on), .ov_thr_sel_o(thr_sel)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic ov_pulse();
    @(negedge clk); ov = 1'b1;
    @(negedge clk); ov = 1'b0;
  endtask

  task automatic reclear();
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1;
    cyc(1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b0; uvlo = 1'b0; ss = 1'b0; ovm = 1'b0;
    ov = 1'b0; uv = 1'b0; oc = 1'b0;
    cyc(3);
    chk("R1 pgood in reset", pgood, 1'b0);
    chk("R1 drv_en in reset", drv_en, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    cyc(4);
    chk("R1 drv_en idle", drv_en, 1'b0);
    chk("R1 ss_run idle", ss_run, 1'b0);
    chk("R1 hs_off idle", hs_off, 1'b0);
    chk("R1 ls_on idle", ls_on, 1'b0);
  endtask

  task automatic t_pgood();
    @(negedge clk); en = 1'b1; ss = 1'b1; #1;
    chk("R2 pgood during ss", pgood, 1'b0);
    chk("R9 ss_run enabled", ss_run, 1'b1);
    @(negedge clk); ss = 1'b0; #1;
    chk("R2 pgood after ss", pgood, 1'b1);
    chk("R2 drv_en on", drv_en, 1'b1);
  endtask

  task automatic t_ov_override();
    @(negedge clk); ov = 1'b1; #1;
    chk("R3 hs_off", hs_off, 1'b1);
    chk("R3 ls_on", ls_on, 1'b1);
    chk("R3 pgood low", pgood, 1'b0);
    @(negedge clk); ov = 1'b0; #1;
    chk("R3 hs_off released", hs_off, 1'b0);
    chk("R3 pgood back", pgood, 1'b1);
    chk("R3 drv_en kept", drv_en, 1'b1);
    reclear();
  endtask

  task automatic t_trip8();
    for (int i = 0; i < 7; i++) ov_pulse();
    cyc(1);
    chk("R4 seven trips no shutdown", drv_en, 1'b1);
    @(negedge clk); ov = 1'b1;
    cyc(1);
    chk("R4 eighth trip drv_en", drv_en, 1'b0);
    chk("R4 eighth trip ls_on", ls_on, 1'b0);
    @(negedge clk); ov = 1'b0;
    cyc(3);
    chk("R4 shutdown held drv_en", drv_en, 1'b0);
    chk("R4 shutdown held hs_off", hs_off, 1'b1);
    reclear();
    chk("R8 enable cycle clears shutdown", drv_en, 1'b1);
  endtask

  task automatic t_softstart();
    @(negedge clk); ss = 1'b1;
    for (int i = 0; i < 10; i++) ov_pulse();
    @(negedge clk); ss = 1'b0; #1;
    chk("R5 no shutdown from ss trips", drv_en, 1'b1);
    for (int i = 0; i < 7; i++) ov_pulse();
    cyc(1);
    chk("R5 ss trips not counted", drv_en, 1'b1);
    reclear();
  endtask

  task automatic t_uv();
    @(negedge clk); uv = 1'b1;
    cyc(UVN - 1);
    chk("R6 pgood before timeout", pgood, 1'b1);
    cyc(1);
    chk("R6 pgood at timeout", pgood, 1'b0);
    @(negedge clk); uv = 1'b0;
    cyc(1);
    chk("R6 pgood after uv clear", pgood, 1'b1);
    @(negedge clk); uv = 1'b1;
    cyc(UVN - 2);
    @(negedge clk); uv = 1'b0;
    @(negedge clk); uv = 1'b1;
    cyc(UVN - 1);
    chk("R6 restart after drop", pgood, 1'b1);
    @(negedge clk); uv = 1'b0;
    cyc(1);
  endtask

  task automatic t_oc();
    @(negedge clk); oc = 1'b1; #1;
    chk("R7 immediate drv_en", drv_en, 1'b0);
    chk("R7 immediate pgood", pgood, 1'b0);
    @(negedge clk); oc = 1'b0;
    @(negedge clk); ss = 1'b1;
    @(negedge clk); ss = 1'b0;
    cyc(1);
    chk("R7 latched drv_en", drv_en, 1'b0);
    chk("R7 latched pgood", pgood, 1'b0);
    @(negedge clk); uvlo = 1'b1; #1;
    chk("R9 uvlo drv_en", drv_en, 1'b0);
    chk("R9 uvlo ss_run", ss_run, 1'b0);
    @(negedge clk); uvlo = 1'b0;
    cyc(1);
    chk("R8 uvlo cycle clears latch", drv_en, 1'b1);
  endtask

  task automatic t_mode();
    @(negedge clk); ovm = 1'b1; #1;
    chk("R10 sel high", thr_sel, 1'b1);
    @(negedge clk); ovm = 1'b0; #1;
    chk("R10 sel low", thr_sel, 1'b0);
  endtask

  initial begin
    t_reset();
    t_pgood();
    t_ov_override();
    t_trip8();
    t_softstart();
    t_uv();
    t_oc();
    t_mode();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule